// File: doc/BRIEF.md
# Bit-Slice Pattern Match Engine

This block evaluates a sum of products over a small set of external inputs. It has eight slices. Each slice picks one of eight synchronised inputs and tests it against a condition selected by a 3-bit code. The code can ask for a level, a current-cycle edge, a remembered (sticky) edge, always-true or never-true. Consecutive slices are ANDed into a product term. A slice flagged as an endpoint closes the running term, and that term's result appears at the endpoint slice's bit of an 8-bit match status. The highest slice always closes a term. All status bits are ORed into a single combined match output, which an enable bit in the control register can mask.

Software programs the engine through three word registers: source selection, slice configuration and control. The control register also returns the status. Remembered edges stay set until software writes the source register. Any value counts, including the value the register already holds. This gives a cheap way to re-arm the detector after an event has been serviced.

Top module: `pm_engine`

## Requirements
- R1: After reset every condition field holds code 6 (never), all endpoint flags, the source register and the control register read 0, and the status and `match_o` are 0.
- R2: Register address 0 is the source register: slice n's input select sits at bits [8+3n +: 3]. Address 1 is the configuration register: slice n's condition code sits at bits [8+3n +: 3], and bit n (n = 0..6) is slice n's endpoint flag. Address 2 is the control register: bit 0 is the combined-output enable, and bits [31:24] hold the read-only status, bit k for slice k. Written fields read back unchanged, and unused bits read 0.
- R3: Slice 7 always ends a product term, and the configuration register has no endpoint flag for it (bit 7 reads 0).
- R4: Condition codes 0 (always), 4 (input high), 5 (input low) and 6 (never) are evaluated on the current synchronised input level.
- R5: A product term is the AND of every slice after the previous endpoint, up to and including the current endpoint. Its result appears only at the endpoint's status bit. Status bits of non-endpoint slices read 0.
- R6: Codes 1 (rising), 2 (falling) and 3 (either edge) match from the cycle the selected edge is seen and keep matching after it, until the detect logic is reset.
- R7: Any write to the source register clears every remembered edge. The status reflects the cleared state one clock after the write.
- R8: Code 7 matches only in the single cycle in which an edge, either direction, is seen on the selected input.
- R9: `match_o` is the OR of all status bits while the enable bit is 1, and is 0 while it is 0.
- R10: An input change reaches the status after three rising clock edges: two synchroniser stages and one output register. A configuration or control write takes effect on the status one edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address for write and read |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` (combinational) |
| pins_i | input | 8 | Asynchronous inputs to be matched |
| match_o | output | 1 | Combined match output, registered |

## Verification
The bench builds the engine with its defaults: eight slices, eight inputs, two synchroniser stages, a 32-bit register word, fields starting at bit 8 and status at bit 24. With these values every condition code is reachable on slice 0. Slice 7 closes the chain while it runs through all earlier slices. The status field can be read in the same word as the enable bit. Every register field is therefore exercised at its real position, and the three-edge input latency can be checked to the exact cycle.

// File: rtl/pm_pkg.sv
package pm_pkg;

    // width of one source select and of one condition code
    localparam int unsigned SEL_W  = 3;
    localparam int unsigned CODE_W = 3;
    localparam int unsigned NUM_INPUTS = 1 << SEL_W;

    typedef enum logic [CODE_W-1:0] {
        COND_ALWAYS      = 3'd0,
        COND_RISE_STICKY = 3'd1,
        COND_FALL_STICKY = 3'd2,
        COND_ANY_STICKY  = 3'd3,
        COND_HIGH        = 3'd4,
        COND_LOW         = 3'd5,
        COND_NEVER       = 3'd6,
        COND_EVENT       = 3'd7
    } cond_e;

    typedef enum logic [1:0] {
        ADDR_SRC  = 2'd0,
        ADDR_CFG  = 2'd1,
        ADDR_CTRL = 2'd2,
        ADDR_NONE = 2'd3
    } reg_addr_e;

endpackage

// File: rtl/pm_sync.sv
// Multi-stage input synchroniser plus one extra stage holding the previous
// synchronised value for edge detection.
module pm_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] cur_o,
    output logic [WIDTH-1:0] prev_o
);

    localparam int unsigned DEPTH = STAGES + 1;

    logic [DEPTH-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = async_i;
        for (int i = 1; i < int'(DEPTH); i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign cur_o  = pipe_q[STAGES-1];
    assign prev_o = pipe_q[STAGES];

endmodule

// File: rtl/pm_slice.sv
// One slice: input select, condition evaluation and the remembered-edge latch.
module pm_slice
    import pm_pkg::*;
(
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [NUM_INPUTS-1:0] cur_i,
    input  logic [NUM_INPUTS-1:0] prev_i,
    input  logic [SEL_W-1:0]      sel_i,
    input  cond_e                 code_i,
    input  logic                  clr_i,
    output logic                  hit_o
);

    logic sticky_d, sticky_q;
    logic lvl, old, rise, fall, arm;

    always_comb begin
        lvl  = cur_i[sel_i];
        old  = prev_i[sel_i];
        rise = lvl & ~old;
        fall = ~lvl & old;
        arm  = 1'b0;
        hit_o = 1'b0;
        unique case (code_i)
            COND_ALWAYS:      hit_o = 1'b1;
            COND_RISE_STICKY: begin arm = rise;        hit_o = sticky_q | rise;        end
            COND_FALL_STICKY: begin arm = fall;        hit_o = sticky_q | fall;        end
            COND_ANY_STICKY:  begin arm = rise | fall; hit_o = sticky_q | rise | fall; end
            COND_HIGH:        hit_o = lvl;
            COND_LOW:         hit_o = ~lvl;
            COND_NEVER:       hit_o = 1'b0;
            COND_EVENT:       hit_o = rise | fall;
            default:          hit_o = 1'b0;
        endcase
        // a detect-logic reset wins over an edge seen in the same cycle
        sticky_d = clr_i ? 1'b0 : (sticky_q | arm);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sticky_q <= 1'b0;
        end else begin
            sticky_q <= sticky_d;
        end
    end

    // R7: the remembered edge is gone after a detect-logic reset
    assert_sticky_cleared_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> !sticky_q);

    // R8: an event match needs the selected input to differ from its previous value
    assert_event_needs_edge_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (code_i == COND_EVENT && hit_o) |-> (cur_i[sel_i] != prev_i[sel_i]));

    // R4: a never-slice contributes no match
    assert_never_silent_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (code_i == COND_NEVER) |-> !hit_o);

endmodule

// File: rtl/pm_chain.sv
// Splits the slice results into product terms at the endpoint flags.
module pm_chain #(
    parameter int unsigned NUM_SLICES = 8
) (
    input  logic [NUM_SLICES-1:0] hit_i,
    input  logic [NUM_SLICES-1:0] end_i,
    output logic [NUM_SLICES-1:0] term_o
);

    always_comb begin
        logic run;
        run = 1'b1;
        for (int n = 0; n < int'(NUM_SLICES); n++) begin
            run       = run & hit_i[n];
            term_o[n] = end_i[n] & run;
            if (end_i[n]) begin
                run = 1'b1;
            end
        end
    end

endmodule

// File: rtl/pm_engine.sv
module pm_engine
    import pm_pkg::*;
#(
    parameter int unsigned NUM_SLICES   = 8,
    parameter int unsigned SYNC_STAGES  = 2,
    parameter int unsigned DATA_W       = 32,
    parameter int unsigned FIELD_BASE   = 8,
    parameter int unsigned STATUS_SHIFT = 24
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  reg_we_i,
    input  logic [1:0]            reg_addr_i,
    input  logic [DATA_W-1:0]     reg_wdata_i,
    output logic [DATA_W-1:0]     reg_rdata_o,
    input  logic [NUM_INPUTS-1:0] pins_i,
    output logic                  match_o
);

    localparam int unsigned STRIDE = 3;
    localparam int unsigned EP_W   = NUM_SLICES - 1;

    function automatic logic [DATA_W-1:0] field_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int n = 0; n < int'(NUM_SLICES); n++) begin
            m[FIELD_BASE + STRIDE*n +: STRIDE] = '1;
        end
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] never_cfg();
        logic [DATA_W-1:0] v;
        v = '0;
        for (int n = 0; n < int'(NUM_SLICES); n++) begin
            v[FIELD_BASE + STRIDE*n +: STRIDE] = COND_NEVER;
        end
        return v;
    endfunction

    localparam logic [DATA_W-1:0] SRC_MASK = field_mask();
    localparam logic [DATA_W-1:0] CFG_MASK = field_mask() | DATA_W'((64'd1 << EP_W) - 64'd1);
    localparam logic [DATA_W-1:0] CFG_RST  = never_cfg();

    typedef struct packed {
        logic [DATA_W-1:0]     src;
        logic [DATA_W-1:0]     cfg;
        logic                  en;
        logic [NUM_SLICES-1:0] status;
        logic                  match;
    } state_t;

    state_t state_d, state_q;

    logic                  clr_det;
    logic [NUM_INPUTS-1:0] sync_cur, sync_prev;
    logic [NUM_SLICES-1:0] hit, ep_vec, term;
    logic                  all_never;

    pm_sync #(
        .WIDTH  (NUM_INPUTS),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (pins_i),
        .cur_o   (sync_cur),
        .prev_o  (sync_prev)
    );

    for (genvar n = 0; n < NUM_SLICES; n++) begin : g_slice
        pm_slice i_slice (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .cur_i  (sync_cur),
            .prev_i (sync_prev),
            .sel_i  (state_q.src[FIELD_BASE + STRIDE*n +: SEL_W]),
            .code_i (cond_e'(state_q.cfg[FIELD_BASE + STRIDE*n +: CODE_W])),
            .clr_i  (clr_det),
            .hit_o  (hit[n])
        );
        if (n == NUM_SLICES - 1) begin : g_last
            assign ep_vec[n] = 1'b1;
        end else begin : g_flag
            assign ep_vec[n] = state_q.cfg[n];
        end
    end

    pm_chain #(
        .NUM_SLICES (NUM_SLICES)
    ) i_chain (
        .hit_i  (hit),
        .end_i  (ep_vec),
        .term_o (term)
    );

    always_comb begin
        state_d = state_q;
        clr_det = 1'b0;
        if (reg_we_i) begin
            unique case (reg_addr_e'(reg_addr_i))
                ADDR_SRC: begin
                    state_d.src = reg_wdata_i & SRC_MASK;
                    clr_det     = 1'b1;
                end
                ADDR_CFG:  state_d.cfg = reg_wdata_i & CFG_MASK;
                ADDR_CTRL: state_d.en  = reg_wdata_i[0];
                default: ;
            endcase
        end
        state_d.status = term;
        state_d.match  = state_q.en & (|term);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '{src: '0, cfg: CFG_RST, en: 1'b0, status: '0, match: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        unique case (reg_addr_e'(reg_addr_i))
            ADDR_SRC: reg_rdata_o = state_q.src;
            ADDR_CFG: reg_rdata_o = state_q.cfg;
            ADDR_CTRL: begin
                reg_rdata_o[0] = state_q.en;
                reg_rdata_o[STATUS_SHIFT +: NUM_SLICES] = state_q.status;
            end
            default: reg_rdata_o = '0;
        endcase
    end

    always_comb begin
        all_never = 1'b1;
        for (int n = 0; n < int'(NUM_SLICES); n++) begin
            if (state_q.cfg[FIELD_BASE + STRIDE*n +: CODE_W] != COND_NEVER) begin
                all_never = 1'b0;
            end
        end
    end

    assign match_o = state_q.match;

    // R5: a status bit can only be set at a slice that closed a term
    assert_status_at_endpoint_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q.status & ~$past(ep_vec)) == '0);

    // R4: with every slice disabled nothing can match
    assert_all_never_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        all_never |=> (state_q.status == '0));

    // R9: the combined output implies some status bit
    assert_match_has_status_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_q.match |-> (|state_q.status));

    // R9: disabled engine keeps the combined output low
    assert_disabled_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !state_q.en |=> !state_q.match);

endmodule

// File: tb/test_pm_engine.sv
module test_pm_engine;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        we;
    logic [1:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [7:0]  pins;
    logic        match;

    always #2 clk = ~clk;   // 250 MHz

    pm_engine i_pm_engine (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .reg_we_i    (we),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .pins_i      (pins),
        .match_o     (match)
    );

    typedef struct {
        int         due;
        logic [7:0] st;
        logic       m;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   cyc   = 0;
    int   total = 0;
    int   bad   = 0;

    logic [2:0] codes [8];
    logic [6:0] eps;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compares status (read through the control register) and match_o
    always @(negedge clk) begin
        #1;
        while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
            exp_t it;
            it = exp_q.pop_front();
            total++;
            if (rdata[31:24] !== it.st || match !== it.m) begin
                bad++;
                $display("FAIL %s: actual status=%h match=%b expected status=%h match=%b",
                         it.tag, rdata[31:24], match, it.st, it.m);
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic expect_in(int n, logic [7:0] st, logic m, string tag);
        exp_q.push_back('{cyc + n, st, m, tag});
    endtask

    task automatic drain();
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        drain();
        we = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0; addr = 2'd2; wdata = '0;
    endtask

    task automatic rd_chk(logic [1:0] a, logic [31:0] exp, string tag);
        drain();
        addr = a;
        #0.5;
        chk(tag, rdata, exp);
        addr = 2'd2;
    endtask

    task automatic set_pins(logic [7:0] v);
        drain();
        pins = v;
    endtask

    function automatic logic [31:0] cfg_val();
        logic [31:0] v;
        v = {25'd0, eps};
        for (int n = 0; n < 8; n++) v[8 + 3*n +: 3] = codes[n];
        return v;
    endfunction

    task automatic codes_never();
        for (int n = 0; n < 8; n++) codes[n] = 3'd6;
        eps = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; we = 1'b0; addr = 2'd2; wdata = '0; pins = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        codes_never();
        rd_chk(2'd1, cfg_val(), "R1 reset configuration");
        rd_chk(2'd0, 32'h0, "R1 reset source");
        rd_chk(2'd2, 32'h0, "R1 reset control");
        expect_in(0, 8'h00, 1'b0, "R1 reset status");
        chk("R1 reset match_o", {31'd0, match}, 32'd0);

        // R2 / R3: register map, masking, no flag for slice 7
        wr(2'd1, 32'h0000_00FF);
        rd_chk(2'd1, 32'h0000_007F, "R3 no endpoint flag for slice 7");
        codes_never();
        codes[0] = 3'd4; eps = 7'b0000001;
        wr(2'd1, cfg_val());
        wr(2'd0, 32'h0000_0200);            // slice 0 <- input 2
        wr(2'd2, 32'h0000_0001);
        rd_chk(2'd0, 32'h0000_0200, "R2 source readback");
        rd_chk(2'd1, cfg_val(), "R2 configuration readback");

        // R4 / R10: level high with three-edge latency
        set_pins(8'h04);
        expect_in(2, 8'h00, 1'b0, "R10 not yet after two edges");
        expect_in(3, 8'h01, 1'b1, "R4 high level match");
        set_pins(8'h00);
        expect_in(3, 8'h00, 1'b0, "R4 high level released");

        // R4: level low, config takes effect one edge after write
        codes[0] = 3'd5;
        wr(2'd1, cfg_val());
        expect_in(1, 8'h01, 1'b1, "R10 low level after config write");
        set_pins(8'h04);
        expect_in(3, 8'h00, 1'b0, "R4 low level released");
        set_pins(8'h00);
        drain();
        repeat (4) @(negedge clk);

        // R5: product term of slices 0 and 1
        codes_never();
        codes[0] = 3'd4; codes[1] = 3'd4; eps = 7'b0000010;
        wr(2'd0, 32'h0000_0800);            // slice0 <- in0, slice1 <- in1
        wr(2'd1, cfg_val());
        set_pins(8'h01);
        expect_in(3, 8'h00, 1'b0, "R5 one term input only");
        set_pins(8'h03);
        expect_in(3, 8'h02, 1'b1, "R5 full product at endpoint bit");
        eps = 7'b0000011;
        wr(2'd1, cfg_val());
        expect_in(1, 8'h03, 1'b1, "R5 split into two terms");
        set_pins(8'h01);
        expect_in(3, 8'h01, 1'b1, "R5 split terms independent");
        set_pins(8'h00);

        // R3: slice 7 closes a chain reaching back to the last endpoint
        for (int n = 0; n < 8; n++) codes[n] = 3'd0;
        codes[0] = 3'd6; eps = '0;
        wr(2'd1, cfg_val());
        expect_in(1, 8'h00, 1'b0, "R3 chain back to never slice 0");
        eps = 7'b0000001;
        wr(2'd1, cfg_val());
        expect_in(1, 8'h80, 1'b1, "R3 slice 7 term after endpoint 0");

        // R9: enable masks the combined output only
        wr(2'd2, 32'h0);
        expect_in(1, 8'h80, 1'b0, "R9 disabled combined output");
        rd_chk(2'd2, 32'h8000_0000, "R2 status field in control");
        wr(2'd2, 32'h1);
        expect_in(1, 8'h80, 1'b1, "R9 re-enabled combined output");

        // R6 / R7: sticky rising on input 3
        codes_never();
        codes[0] = 3'd1; eps = 7'b0000001;
        wr(2'd1, cfg_val());
        wr(2'd0, 32'h0000_0300);
        expect_in(1, 8'h00, 1'b0, "R6 rising idle");
        set_pins(8'h08);
        expect_in(3, 8'h01, 1'b1, "R6 rising seen");
        set_pins(8'h00);
        expect_in(3, 8'h01, 1'b1, "R6 rising remembered");
        wr(2'd0, 32'h0000_0300);            // same value still clears
        expect_in(0, 8'h01, 1'b1, "R7 status on write edge");
        expect_in(1, 8'h00, 1'b0, "R7 cleared by source write");
        expect_in(4, 8'h00, 1'b0, "R7 stays cleared");

        // R6: sticky falling
        codes[0] = 3'd2;
        wr(2'd1, cfg_val());
        set_pins(8'h08);
        expect_in(3, 8'h00, 1'b0, "R6 falling ignores rise");
        set_pins(8'h00);
        expect_in(3, 8'h01, 1'b1, "R6 falling seen");
        expect_in(6, 8'h01, 1'b1, "R6 falling remembered");

        // R6: either edge
        codes[0] = 3'd3;
        wr(2'd1, cfg_val());
        wr(2'd0, 32'h0000_0300);
        expect_in(1, 8'h00, 1'b0, "R7 clear before either-edge");
        set_pins(8'h08);
        expect_in(3, 8'h01, 1'b1, "R6 either edge seen");

        // R8: single-cycle event
        codes[0] = 3'd7;
        wr(2'd1, cfg_val());
        expect_in(1, 8'h00, 1'b0, "R8 no edge no event");
        set_pins(8'h00);
        expect_in(3, 8'h01, 1'b1, "R8 event on edge");
        expect_in(4, 8'h00, 1'b0, "R8 event lasts one cycle");

        drain();
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule